// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the processor-facing register front end of a UART whose shift engine and 128-deep transmit and receive FIFOs live elsewhere. Software reaches it through a simple single-cycle register bus with word-aligned offsets. A write to the transmit data register becomes a push strobe toward the transmit FIFO. A read of the receive data register becomes a pop strobe toward the receive FIFO. The block also exposes the FIFO fill levels, the error flags of the receiver and the programmed line, control and baud divisor settings.

Four interrupt sources feed one level interrupt. Receive-full and transmit-empty follow the FIFO fill levels against programmable thresholds. Break-detect and receive-timeout are latched from single-cycle event inputs and stay pending until software clears them. Each source has an enable bit, and a masked-status register shows the pending sources that are enabled. A DMA enable bit in control register 1 gates a registered request output.

Top module: `uart_regfile`

## Requirements
- R1: After a synchronous reset the line control register reads 0x1C (8 data bits, 1 stop bit). Control 1, enable and masked status read 0, and `irq` and `dma_req` are 0.
- R2: Control 1 (offset 0x1C) keeps bits 15:0 and drives `ctrl1`. Line control (0x18) keeps bits 7:0 and drives `line_ctrl`. The threshold register (0x20) keeps the receive-full threshold in bits 6:0 and the transmit-empty threshold in bits 14:8, and reads 0 elsewhere.
- R3: Divisor low (0x24) keeps bits 15:0 and divisor high (0x28) keeps bits 4:0. `divisor` is {high[4:0], low[15:0]}.
- R4: The FIFO count register (0x0C) reads the receive count in bits 7:0 and the transmit count in bits 15:8.
- R5: Line status (0x08) reads parity error at bit 2, framing error at bit 3, overrun at bit 4, break at bit 7 and transmitter idle at bit 15, all taken from the matching inputs.
- R6: Raw receive-full is 1 while the receive count is at or above its threshold. Raw transmit-empty is 1 while the transmit count is at or below its threshold.
- R7: Interrupt bits sit at receive-full 0, transmit-empty 1, break 7 and timeout 13 in the enable (0x10), clear (0x14) and masked-status (0x2C) registers. Masked status is raw pending AND enable. `irq` is the OR of the masked bits, registered one cycle later.
- R8: Break and timeout are latched from `brk_evt` and `tmo_evt` and stay pending whether or not they are enabled, until a one is written to their bit at 0x14. Writing bits 0 or 1 there has no effect. An event in the same cycle as its clear leaves the source pending.
- R9: A write to offset 0x00 pulses `tx_push` in that cycle with `tx_byte` equal to write data bits 7:0. When `tx_full` is 1 the write is dropped and `tx_push` stays 0.
- R10: A read of offset 0x04 pulses `rx_pop` in that cycle and returns `rx_byte` in read data bits 7:0. A read of any other offset leaves `rx_pop` at 0.
- R11: `dma_req` is registered: it is 1 one cycle after control 1 bit 15 is set while raw receive-full or raw transmit-empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| tx_full | input | 1 | Transmit FIFO full |
| tx_count | input | 8 | Transmit FIFO fill level |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_byte | input | 8 | Head of the receive FIFO |
| rx_count | input | 8 | Receive FIFO fill level |
| st_parity | input | 1 | Parity error flag |
| st_frame | input | 1 | Framing error flag |
| st_overrun | input | 1 | Overrun flag |
| st_break | input | 1 | Break flag |
| tx_idle | input | 1 | Transmitter idle |
| brk_evt | input | 1 | One-cycle break-detected event |
| tmo_evt | input | 1 | One-cycle receive-timeout event |
| line_ctrl | output | 8 | Line control setting |
| ctrl1 | output | 16 | Control 1 setting |
| divisor | output | 21 | Baud divisor |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The hardest case to reach is a break event that lands in the same clock cycle as the software write that clears break. From the ports that collision happens only when the write timing and the event timing line up exactly. The bench drives `brk_evt` on the same falling edge that starts the clear write, so both are sampled at one rising edge. A later masked-status read must still show the break pending. The threshold edges are set up by moving the fill-level inputs one step either side of each programmed threshold.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  // word index = byte offset / 4; software decodes these, so they are fixed
  typedef enum logic [3:0] {
    IDX_TXD  = 4'd0,
    IDX_RXD  = 4'd1,
    IDX_LSR  = 4'd2,
    IDX_CNT  = 4'd3,
    IDX_IEN  = 4'd4,
    IDX_ICLR = 4'd5,
    IDX_LCR  = 4'd6,
    IDX_CTL1 = 4'd7,
    IDX_THR  = 4'd8,
    IDX_DIVL = 4'd9,
    IDX_DIVH = 4'd10,
    IDX_IMS  = 4'd11
  } reg_idx_e;

  localparam int NUM_REGS = 12;

  localparam int BIT_RXF = 0;
  localparam int BIT_TXE = 1;
  localparam int BIT_BRK = 7;
  localparam int BIT_TMO = 13;

  localparam logic [7:0] LCR_RESET = 8'h1C;

  typedef struct packed {
    logic tmo;
    logic brk;
    logic txe;
    logic rxf;
  } irq_vec_t;

  function automatic irq_vec_t word_to_irq(input logic [31:0] w);
    irq_vec_t v;
    v.tmo = w[BIT_TMO];
    v.brk = w[BIT_BRK];
    v.txe = w[BIT_TXE];
    v.rxf = w[BIT_RXF];
    return v;
  endfunction

  function automatic logic [31:0] irq_to_word(input irq_vec_t v);
    logic [31:0] w;
    w = '0;
    w[BIT_TMO] = v.tmo;
    w[BIT_BRK] = v.brk;
    w[BIT_TXE] = v.txe;
    w[BIT_RXF] = v.rxf;
    return w;
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                sel,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    logic match;
    assign match     = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    assign wr_hit[i] = sel &&  wr && match;
    assign rd_hit[i] = sel && !wr && match;
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  input  logic             brk_evt,
  input  logic             tmo_evt,
  input  logic             clr_we,
  input  irq_vec_t         clr_bits,
  input  irq_vec_t         enable,
  output irq_vec_t         pend,
  output irq_vec_t         masked,
  output logic             irq
);
  logic brk_q, tmo_q;

  // event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      brk_q <= (brk_q && !(clr_we && clr_bits.brk)) || brk_evt;
      tmo_q <= (tmo_q && !(clr_we && clr_bits.tmo)) || tmo_evt;
    end
  end

  always_comb begin
    pend.rxf = (rx_count >= CNT_W'(rx_thr));
    pend.txe = (tx_count <= CNT_W'(tx_thr));
    pend.brk = brk_q;
    pend.tmo = tmo_q;
  end

  assign masked = pend & enable;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 128,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int THR_W      = 7,
  parameter int DIV_LO_W   = 16,
  parameter int DIV_HI_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         tx_push,
  output logic [7:0]                   tx_byte,
  input  logic                         tx_full,
  input  logic [CNT_W-1:0]             tx_count,
  output logic                         rx_pop,
  input  logic [7:0]                   rx_byte,
  input  logic [CNT_W-1:0]             rx_count,
  input  logic                         st_parity,
  input  logic                         st_frame,
  input  logic                         st_overrun,
  input  logic                         st_break,
  input  logic                         tx_idle,
  input  logic                         brk_evt,
  input  logic                         tmo_evt,
  output logic [7:0]                   line_ctrl,
  output logic [15:0]                  ctrl1,
  output logic [DIV_HI_W+DIV_LO_W-1:0] divisor,
  output logic                         irq,
  output logic                         dma_req
);
  localparam int TX_THR_POS = 8;
  localparam int TX_CNT_POS = 8;
  localparam int DMA_EN_BIT = 15;

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  irq_vec_t            ien_q, pend, masked;
  logic [THR_W-1:0]    rx_thr_q, tx_thr_q;
  logic [DIV_LO_W-1:0] div_lo_q;
  logic [DIV_HI_W-1:0] div_hi_q;
  logic [31:0]         rd_word;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  uart_rf_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_thr   (rx_thr_q),
    .tx_thr   (tx_thr_q),
    .brk_evt  (brk_evt),
    .tmo_evt  (tmo_evt),
    .clr_we   (wr_hit[IDX_ICLR]),
    .clr_bits (word_to_irq(bus_wdata)),
    .enable   (ien_q),
    .pend     (pend),
    .masked   (masked),
    .irq      (irq)
  );

  // FIFO strobes follow the access in the same cycle
  assign tx_push = wr_hit[IDX_TXD] && !tx_full;
  assign tx_byte = bus_wdata[7:0];
  assign rx_pop  = rd_hit[IDX_RXD];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      line_ctrl <= LCR_RESET;
      ctrl1     <= '0;
      rx_thr_q  <= '0;
      tx_thr_q  <= '0;
      div_lo_q  <= '0;
      div_hi_q  <= '0;
    end else begin
      if (wr_hit[IDX_IEN])  ien_q     <= word_to_irq(bus_wdata);
      if (wr_hit[IDX_LCR])  line_ctrl <= bus_wdata[7:0];
      if (wr_hit[IDX_CTL1]) ctrl1     <= bus_wdata[15:0];
      if (wr_hit[IDX_THR]) begin
        rx_thr_q <= bus_wdata[THR_W-1:0];
        tx_thr_q <= bus_wdata[TX_THR_POS +: THR_W];
      end
      if (wr_hit[IDX_DIVL]) div_lo_q  <= bus_wdata[DIV_LO_W-1:0];
      if (wr_hit[IDX_DIVH]) div_hi_q  <= bus_wdata[DIV_HI_W-1:0];
    end
  end

  assign divisor = {div_hi_q, div_lo_q};

  // read data selection
  always_comb begin
    rd_word = '0;
    if (rd_hit[IDX_RXD]) rd_word[7:0] = rx_byte;
    if (rd_hit[IDX_LSR]) begin
      rd_word[2]  = st_parity;
      rd_word[3]  = st_frame;
      rd_word[4]  = st_overrun;
      rd_word[7]  = st_break;
      rd_word[15] = tx_idle;
    end
    if (rd_hit[IDX_CNT]) begin
      rd_word[CNT_W-1:0]             = rx_count;
      rd_word[TX_CNT_POS +: CNT_W]   = tx_count;
    end
    if (rd_hit[IDX_IEN])  rd_word = irq_to_word(ien_q);
    if (rd_hit[IDX_LCR])  rd_word[7:0] = line_ctrl;
    if (rd_hit[IDX_CTL1]) rd_word[15:0] = ctrl1;
    if (rd_hit[IDX_THR]) begin
      rd_word[THR_W-1:0]          = rx_thr_q;
      rd_word[TX_THR_POS +: THR_W] = tx_thr_q;
    end
    if (rd_hit[IDX_DIVL]) rd_word[DIV_LO_W-1:0] = div_lo_q;
    if (rd_hit[IDX_DIVH]) rd_word[DIV_HI_W-1:0] = div_hi_q;
    if (rd_hit[IDX_IMS])  rd_word = irq_to_word(masked);
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (|rd_hit) bus_rdata <= rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= ctrl1[DMA_EN_BIT] && (pend.rxf || pend.txe);
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tx_push,
  input logic              tx_full,
  input logic              rx_pop,
  input logic              irq,
  input logic              dma_req,
  input logic [15:0]       ctrl1,
  input logic [7:0]        line_ctrl,
  input irq_vec_t          ien_q,
  input irq_vec_t          pend
);
  logic clr_tmo;
  assign clr_tmo = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h14)) && bus_wdata[BIT_TMO];

  assert_reset_lcr_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (line_ctrl == LCR_RESET));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(pend & ien_q)));

  assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pend.tmo) && !$past(clr_tmo)) |-> pend.tmo);

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (!tx_full && bus_sel && bus_wr && bus_addr == '0));

  assert_pop_decode_R10: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h04)));

  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(ctrl1[15]));
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tx_push   (tx_push),
  .tx_full   (tx_full),
  .rx_pop    (rx_pop),
  .irq       (irq),
  .dma_req   (dma_req),
  .ctrl1     (ctrl1),
  .line_ctrl (line_ctrl),
  .ien_q     (ien_q),
  .pend      (pend)
);

// File: tb/uart_regfile_bench.sv
`timescale 1ns/1ps
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_push, rx_pop, irq, dma_req;
  logic [7:0]  tx_byte, line_ctrl;
  logic        tx_full = 1'b0;
  logic [7:0]  tx_count = '0, rx_count = '0, rx_byte = '0;
  logic        st_parity = 0, st_frame = 0, st_overrun = 0, st_break = 0, tx_idle = 0;
  logic        brk_evt = 0, tmo_evt = 0;
  logic [15:0] ctrl1;
  logic [20:0] divisor;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_flag = 1'b0;

  always #5 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_byte(tx_byte),
    .tx_full(tx_full), .tx_count(tx_count), .rx_pop(rx_pop), .rx_byte(rx_byte),
    .rx_count(rx_count), .st_parity(st_parity), .st_frame(st_frame),
    .st_overrun(st_overrun), .st_break(st_break), .tx_idle(tx_idle),
    .brk_evt(brk_evt), .tmo_evt(tmo_evt), .line_ctrl(line_ctrl), .ctrl1(ctrl1),
    .divisor(divisor), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: a read issued at one edge has its data on the bus by the next falling edge
  always @(posedge clk) rd_flag <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
    rd(6'h18, 32'h1C, "R1 line control");
    rd(6'h1C, 32'h0, "R1 control1");
    rd(6'h10, 32'h0, "R1 enable");
    rd(6'h2C, 32'h0, "R1 masked status");

    // R2 register fields
    wr(6'h1C, 32'hFFFF_C1C0);
    rd(6'h1C, 32'hC1C0, "R2 control1 readback");
    chk("R2 ctrl1 port", ctrl1, 16'hC1C0);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, 32'h7F7F, "R2 threshold fields");
    wr(6'h18, 32'h0000_013F);
    rd(6'h18, 32'h3F, "R2 line control readback");
    chk("R2 line_ctrl port", line_ctrl, 8'h3F);
    wr(6'h1C, 32'h0);

    // R3 divisor split
    wr(6'h24, 32'hABCD_1234);
    wr(6'h28, 32'hFFFF_FFF5);
    rd(6'h24, 32'h1234, "R3 divisor low");
    rd(6'h28, 32'h15, "R3 divisor high");
    chk("R3 divisor port", divisor, 21'h15_1234);

    // R4 counts
    rx_count = 8'd5; tx_count = 8'd128;
    rd(6'h0C, 32'h8005, "R4 count layout");

    // R5 line status
    st_parity = 1; st_frame = 1; st_overrun = 1; st_break = 1; tx_idle = 1;
    rd(6'h08, 32'h809C, "R5 all flags");
    st_parity = 0; st_overrun = 0; st_break = 0; tx_idle = 0;
    rd(6'h08, 32'h0008, "R5 framing only");
    st_frame = 0;

    // R6 / R7 thresholds and masking
    wr(6'h10, 32'h2083);
    wr(6'h20, 32'h0204);
    rx_count = 3; tx_count = 3;
    settle();
    rd(6'h2C, 32'h0, "R6 below rx threshold, above tx threshold");
    chk("R7 irq idle", irq, 0);
    rx_count = 4;
    settle();
    rd(6'h2C, 32'h1, "R6 rx at threshold");
    chk("R7 irq from rx-full", irq, 1);
    rx_count = 0; tx_count = 2;
    settle();
    rd(6'h2C, 32'h2, "R6 tx at threshold");
    tx_count = 3;
    settle();
    rd(6'h2C, 32'h0, "R6 tx above threshold");
    rx_count = 4; tx_count = 2;
    wr(6'h10, 32'h0);
    settle();
    rd(6'h2C, 32'h0, "R7 disabled sources masked");
    chk("R7 irq masked off", irq, 0);
    rx_count = 0; tx_count = 3;

    // R8 sticky sources
    wr(6'h10, 32'h2080);
    @(negedge clk); tmo_evt = 1;
    @(negedge clk); tmo_evt = 0;
    settle();
    rd(6'h2C, 32'h2000, "R8 timeout latched");
    chk("R7 irq from timeout", irq, 1);
    wr(6'h14, 32'h0000_0003);
    rd(6'h2C, 32'h2000, "R8 clear of level bits no effect");
    wr(6'h14, 32'h0000_2000);
    settle();
    rd(6'h2C, 32'h0, "R8 timeout cleared");
    chk("R8 irq after clear", irq, 0);
    wr(6'h10, 32'h0);
    @(negedge clk); brk_evt = 1;
    @(negedge clk); brk_evt = 0;
    rd(6'h2C, 32'h0, "R8 break hidden while disabled");
    wr(6'h10, 32'h0080);
    rd(6'h2C, 32'h80, "R8 break held while disabled");
    wr(6'h14, 32'h80);
    rd(6'h2C, 32'h0, "R8 break cleared");
    // event and clear in the same cycle
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h14; bus_wdata = 32'h80; brk_evt = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; brk_evt = 0;
    rd(6'h2C, 32'h80, "R8 event beats clear");
    wr(6'h14, 32'h80);

    // R9 transmit push
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'h5A;
    #1 chk("R9 push strobe", tx_push, 1);
    chk("R9 push byte", tx_byte, 8'h5A);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    #1 chk("R9 push ends", tx_push, 0);
    tx_full = 1;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'hC3;
    #1 chk("R9 push dropped when full", tx_push, 0);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tx_full = 0;

    // R10 receive pop
    rx_byte = 8'hA5;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'h04;
    exp_q.push_back(32'hA5); tag_q.push_back("R10 receive data");
    #1 chk("R10 pop strobe", rx_pop, 1);
    @(negedge clk);
    bus_sel = 0;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'h08;
    exp_q.push_back(32'h0); tag_q.push_back("R10 status read");
    #1 chk("R10 no pop on other read", rx_pop, 0);
    @(negedge clk);
    bus_sel = 0;

    // R11 DMA request
    wr(6'h1C, 32'h8000);
    rx_count = 4; tx_count = 3;
    settle();
    chk("R11 request with rx-full", dma_req, 1);
    rx_count = 0;
    settle();
    chk("R11 no request without condition", dma_req, 0);
    rx_count = 4;
    wr(6'h1C, 32'h0);
    settle();
    chk("R11 no request when disabled", dma_req, 0);

    settle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule